// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block owns the status byte of a serial memory and decides, transaction by transaction, whether a write may go ahead. The command decoder sends it single-cycle requests: set the write enable latch, clear the write enable latch, write the status byte (with its data), and start an array write at a given address. The block also sees the chip-select level, the active-low write-protect pin, the write engine's busy flag and the engine's cycle-complete pulse. It returns the status byte for reads, a one-cycle permit pulse when a status write is committed, and a one-cycle permit pulse when an array write is allowed to start.

Commands that change protection state are held pending until the end of the chip-select frame and applied on the rising edge of chip select. Because of this, a write issued in the same frame as the enable command is refused. The protection bits (hardware-protect enable and the two-bit range code) are nonvolatile in the end product. Here they are registers whose reset value is a parameter. The address range check compares the start address against top-aligned boundaries that are derived from the address width. No interface carries a stream of data. Every pin is a plain level or a single-cycle pulse sampled on the clock, with no back-pressure.

Top module: `wprot_status_ctrl`

## Requirements
- R1: The status byte reads as bit 7 hardware-protect enable, bits 6 to 4 zero, bits 3:2 range code, bit 1 write enable latch, and bit 0 equal to the `busy` input in the same cycle.
- R2: After reset the write enable latch is 0, the protection bits take the parameter reset value (default all zero), and both permit outputs are 0.
- R3: A set-enable request inside a frame (cs_n low) sets the latch only on the clock that sees cs_n return high. The status byte shows it from the next sample. An array write requested in that same frame is refused.
- R4: A clear-enable request inside a frame clears the latch at frame end. If set and clear are both requested in one frame, the latch ends up clear.
- R5: A `wr_done` pulse clears the write enable latch on the next clock. This takes priority over any frame-end set.
- R6: While `busy` is high, set, clear, status-write and array-write requests are ignored. No permit pulse follows, and the latch and protection bits keep their values.
- R7: A status write commits at frame end only if the latch is 1. It changes bits 7, 3 and 2 alone (data bits 6:4 and 1:0 have no effect) and pulses `sts_wr_ok` for the one cycle after the commit.
- R8: When the enable bit is 1, a low `wp_n` sampled in any cycle of the frame, including the frame-end cycle, refuses the status write. When the enable bit is 0, `wp_n` is ignored. A `wp_n` change after the commit does not alter the committed bits.
- R9: Range code 00 protects no address, 01 protects the top quarter (0x1800–0x1FFF at 13 address bits), 10 the top half (0x1000–0x1FFF) and 11 every address.
- R10: `arr_wr_ok` pulses in the cycle after an array request only when the latch is 1, `busy` is low and the start address is outside the protected range. `wp_n` has no effect on this decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low during a frame; rising edge ends the frame |
| set_wel_req | input | 1 | Pulse: set-write-enable command decoded |
| clr_wel_req | input | 1 | Pulse: clear-write-enable command decoded |
| wrsr_req | input | 1 | Pulse: status-write data byte received |
| wrsr_data | input | 8 | Status-write data, valid with `wrsr_req` |
| arr_wr_req | input | 1 | Pulse: array write start address received |
| arr_addr | input | ADDR_W | Array write start address, valid with `arr_wr_req` |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy | input | 1 | Write engine busy with an internal cycle |
| wr_done | input | 1 | Pulse: internal write cycle completed |
| status_byte | output | 8 | Status byte for reads |
| sts_wr_ok | output | 1 | Pulse: status write committed, start the write cycle |
| arr_wr_ok | output | 1 | Pulse: array write permitted |

## Verification
Two functions meet in one cycle when the write-protect pin falls at the same clock edge as chip select rises to close a status-write frame. In that cycle the frame-end commit and the hardware-protect sampling both act on the same edge. The bench provokes this by driving `cs_n` high and `wp_n` low on the same negative edge while the enable bit is 1. It judges the result by a missing `sts_wr_ok` pulse and by range and enable bits that keep their old values in the status byte. The reverse order is also covered: the pin drops one cycle after a committed write, and the committed bits must stay unchanged.

// File: rtl/wps_pkg.sv
package wps_pkg;

  localparam int SB_HWEN = 7;
  localparam int SB_RG1  = 3;
  localparam int SB_RG0  = 2;
  localparam int SB_WEL  = 1;
  localparam int SB_BUSY = 0;

  // bits a status write may touch
  localparam logic [7:0] SB_WR_MASK = (8'd1 << SB_HWEN) | (8'd1 << SB_RG1) | (8'd1 << SB_RG0);

  typedef enum logic [1:0] {
    RG_NONE    = 2'b00,
    RG_QUARTER = 2'b01,
    RG_HALF    = 2'b10,
    RG_ALL     = 2'b11
  } range_e;

  function automatic logic [7:0] pack_status(logic hwen, range_e rg, logic wel, logic bsy);
    logic [7:0] s;
    s = 8'h00;
    s[SB_HWEN] = hwen;
    s[SB_RG1]  = rg[1];
    s[SB_RG0]  = rg[0];
    s[SB_WEL]  = wel;
    s[SB_BUSY] = bsy;
    return s;
  endfunction

endpackage

// File: rtl/wps_frame.sv
module wps_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic in_frame,
  output logic frame_end
);
  logic cs_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n;
  end

  assign in_frame  = !cs_n;
  assign frame_end = !cs_n_q && cs_n;

  // R3
  frame_end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(!cs_n));

endmodule

// File: rtl/wps_wel.sv
module wps_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic frame_end,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic wr_done,
  output logic wel
);
  logic pend_set_q;
  logic pend_clr_q;
  logic wel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_set_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else if (frame_end) begin
      pend_set_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else if (accept) begin
      if (set_req) pend_set_q <= 1'b1;
      if (clr_req) pend_clr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  wel_q <= 1'b0;
    else if (wr_done)                            wel_q <= 1'b0;
    else if (frame_end && pend_clr_q)            wel_q <= 1'b0;
    else if (frame_end && pend_set_q && !busy)   wel_q <= 1'b1;
  end

  assign wel = wel_q;

  // R3
  wel_set_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(frame_end));

  // R5
  wel_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wel_q);

endmodule

// File: rtl/wps_nvbits.sv
module wps_nvbits
  import wps_pkg::*;
#(
  parameter logic [7:0] RST_NV = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_frame,
  input  logic       accept,
  input  logic       frame_end,
  input  logic       busy,
  input  logic       wel,
  input  logic       wp_n,
  input  logic       wrsr_req,
  input  logic [7:0] wrsr_data,
  output logic       hwen,
  output range_e     rng,
  output logic       commit_pulse
);
  logic [7:0] nv_q;
  logic [7:0] pend_data_q;
  logic       pend_q;
  logic       wp_seen_q;
  logic       commit_q;
  logic       hw_block;
  logic       commit;

  assign hw_block = nv_q[SB_HWEN] && (wp_seen_q || !wp_n);
  assign commit   = frame_end && pend_q && wel && !busy && !hw_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_data_q <= 8'h00;
      wp_seen_q   <= 1'b0;
    end else if (frame_end) begin
      pend_q    <= 1'b0;
      wp_seen_q <= 1'b0;
    end else begin
      if (accept && wrsr_req) begin
        pend_q      <= 1'b1;
        pend_data_q <= wrsr_data;
      end
      if (in_frame && !wp_n) wp_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_q     <= RST_NV & SB_WR_MASK;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit;
      if (commit) nv_q <= (nv_q & ~SB_WR_MASK) | (pend_data_q & SB_WR_MASK);
    end
  end

  assign hwen         = nv_q[SB_HWEN];
  assign rng          = range_e'(nv_q[SB_RG1:SB_RG0]);
  assign commit_pulse = commit_q;

  // R7
  nv_change_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_q != $past(nv_q)) |-> commit_q);

  // R7
  commit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(wel));

  // R8
  hw_protect_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && nv_q[SB_HWEN] && !wp_n) |=> !commit_q);

endmodule

// File: rtl/wps_range.sv
module wps_range
  import wps_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  range_e            rng,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QTR_BASE  = HALF_BASE | (HALF_BASE >> 1);

  always_comb begin
    unique case (rng)
      RG_NONE:    hit = 1'b0;
      RG_QUARTER: hit = (addr >= QTR_BASE);
      RG_HALF:    hit = (addr >= HALF_BASE);
      default:    hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/wprot_status_ctrl.sv
module wprot_status_ctrl
  import wps_pkg::*;
#(
  parameter int         ADDR_W = 13,
  parameter logic [7:0] RST_NV = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              set_wel_req,
  input  logic              clr_wel_req,
  input  logic              wrsr_req,
  input  logic [7:0]        wrsr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              wr_done,
  output logic [7:0]        status_byte,
  output logic              sts_wr_ok,
  output logic              arr_wr_ok
);
  logic   in_frame;
  logic   frame_end;
  logic   accept;
  logic   wel;
  logic   hwen;
  range_e rng;
  logic   addr_hit;
  logic   arr_ok_q;

  assign accept = in_frame && !busy;

  wps_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .in_frame  (in_frame),
    .frame_end (frame_end)
  );

  wps_wel u_wel (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .frame_end (frame_end),
    .busy      (busy),
    .set_req   (set_wel_req),
    .clr_req   (clr_wel_req),
    .wr_done   (wr_done),
    .wel       (wel)
  );

  wps_nvbits #(.RST_NV(RST_NV)) u_nv (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_frame     (in_frame),
    .accept       (accept),
    .frame_end    (frame_end),
    .busy         (busy),
    .wel          (wel),
    .wp_n         (wp_n),
    .wrsr_req     (wrsr_req),
    .wrsr_data    (wrsr_data),
    .hwen         (hwen),
    .rng          (rng),
    .commit_pulse (sts_wr_ok)
  );

  wps_range #(.ADDR_W(ADDR_W)) u_range (
    .rng  (rng),
    .addr (arr_addr),
    .hit  (addr_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) arr_ok_q <= 1'b0;
    else        arr_ok_q <= accept && arr_wr_req && wel && !addr_hit;
  end

  assign arr_wr_ok   = arr_ok_q;
  assign status_byte = pack_status(hwen, rng, wel, busy);

  // R10
  arr_ok_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> $past(wel) && $past(arr_wr_req));

  // R6
  busy_blocks_arr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !arr_wr_ok);

  // R9
  full_range_blocks_arr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> $past(rng) != RG_ALL);

  // R1
  status_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000 && status_byte[0] == busy);

endmodule

// File: tb/tb_wprot_status_ctrl.sv
module tb_wprot_status_ctrl;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          set_wel_req = 1'b0;
  logic          clr_wel_req = 1'b0;
  logic          wrsr_req = 1'b0;
  logic [7:0]    wrsr_data = 8'h00;
  logic          arr_wr_req = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic          wp_n = 1'b1;
  logic          busy = 1'b0;
  logic          wr_done = 1'b0;
  logic [7:0]    status_byte;
  logic          sts_wr_ok;
  logic          arr_wr_ok;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wprot_status_ctrl #(.ADDR_W(AW)) dut (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n),
    .set_wel_req (set_wel_req), .clr_wel_req (clr_wel_req),
    .wrsr_req (wrsr_req), .wrsr_data (wrsr_data),
    .arr_wr_req (arr_wr_req), .arr_addr (arr_addr),
    .wp_n (wp_n), .busy (busy), .wr_done (wr_done),
    .status_byte (status_byte), .sts_wr_ok (sts_wr_ok), .arr_wr_ok (arr_wr_ok)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wren_frame();
    @(negedge clk); cs_n = 1'b0; set_wel_req = 1'b1;
    @(negedge clk); set_wel_req = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrdi_frame();
    @(negedge clk); cs_n = 1'b0; clr_wel_req = 1'b1;
    @(negedge clk); clr_wel_req = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
  endtask

  // returns the commit pulse seen after frame end
  task automatic wrsr_frame(input logic [7:0] d, input logic wp_end, output logic ok);
    @(negedge clk); cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = d;
    @(negedge clk); wrsr_req = 1'b0; cs_n = 1'b1; wp_n = wp_end;
    @(negedge clk); ok = sts_wr_ok;
  endtask

  task automatic arr_try(input logic [AW-1:0] a, output logic ok);
    @(negedge clk); cs_n = 1'b0; arr_wr_req = 1'b1; arr_addr = a;
    @(negedge clk); ok = arr_wr_ok; arr_wr_req = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  // set protection bits with WP high
  task automatic set_nv(input logic [7:0] d);
    logic ok;
    wren_frame();
    wrsr_frame(d, 1'b1, ok);
    done_pulse();
  endtask

  task automatic t_reset();
    chk("R2 reset status", status_byte, 8'h00);
    chk("R2 reset permits", {sts_wr_ok, arr_wr_ok}, 8'h00);
    @(negedge clk); busy = 1'b1; #0;
    chk("R1 busy bit", status_byte, 8'h01);
    busy = 1'b0;
  endtask

  task automatic t_wren();
    @(negedge clk); cs_n = 1'b0; set_wel_req = 1'b1;
    @(negedge clk); set_wel_req = 1'b0; arr_wr_req = 1'b1; arr_addr = 13'h0000;
    chk("R3 wel not yet set", status_byte, 8'h00);
    @(negedge clk); arr_wr_req = 1'b0;
    chk("R3 same-frame array write refused", {7'd0, arr_wr_ok}, 8'h00);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R3 wel after frame end", status_byte, 8'h02);
  endtask

  task automatic t_wrdi();
    wrdi_frame();
    chk("R4 clear at frame end", status_byte, 8'h00);
    @(negedge clk); cs_n = 1'b0; set_wel_req = 1'b1; clr_wel_req = 1'b1;
    @(negedge clk); set_wel_req = 1'b0; clr_wel_req = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    chk("R4 set+clear same frame", status_byte, 8'h00);
  endtask

  task automatic t_wrsr();
    logic ok;
    wrsr_frame(8'hFF, 1'b1, ok);
    chk("R7 refused without wel", {7'd0, ok}, 8'h00);
    chk("R7 bits kept without wel", status_byte, 8'h00);
    wren_frame();
    wrsr_frame(8'h73, 1'b1, ok);
    chk("R7 commit pulse", {7'd0, ok}, 8'h01);
    chk("R7 masked data", status_byte, 8'h02);
    wrsr_frame(8'hFF, 1'b1, ok);
    chk("R7 only bits 7,3,2 change", status_byte, 8'h8E);
    done_pulse();
    chk("R5 done clears wel", status_byte, 8'h8C);
    // done wins over a frame-end set in the same cycle
    @(negedge clk); cs_n = 1'b0; set_wel_req = 1'b1;
    @(negedge clk); set_wel_req = 1'b0; cs_n = 1'b1; wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    chk("R5 done beats frame-end set", status_byte, 8'h8C);
    set_nv(8'h00);  // wp_n high, enable 1: allowed
    chk("R7 clear nv bits", status_byte, 8'h00);
  endtask

  task automatic t_ranges();
    logic ok;
    set_nv(8'h04);
    wren_frame();
    chk("R9 quarter code in status", status_byte, 8'h06);
    arr_try(13'h17FF, ok); chk("R9 quarter below edge", {7'd0, ok}, 8'h01);
    arr_try(13'h1800, ok); chk("R9 quarter at edge", {7'd0, ok}, 8'h00);
    done_pulse();
    set_nv(8'h08);
    wren_frame();
    arr_try(13'h0FFF, ok); chk("R9 half below edge", {7'd0, ok}, 8'h01);
    arr_try(13'h1000, ok); chk("R9 half at edge", {7'd0, ok}, 8'h00);
    done_pulse();
    set_nv(8'h0C);
    wren_frame();
    arr_try(13'h0000, ok); chk("R9 full protects zero", {7'd0, ok}, 8'h00);
    done_pulse();
    set_nv(8'h00);
    arr_try(13'h1FFF, ok); chk("R10 refused without wel", {7'd0, ok}, 8'h00);
    wren_frame();
    arr_try(13'h1FFF, ok); chk("R9 none allows top", {7'd0, ok}, 8'h01);
    done_pulse();
  endtask

  task automatic t_busy();
    logic ok;
    @(negedge clk); busy = 1'b1;
    wren_frame();
    chk("R6 set ignored while busy", status_byte, 8'h01);
    busy = 1'b0;
    wren_frame();
    busy = 1'b1;
    arr_try(13'h0000, ok); chk("R6 array refused while busy", {7'd0, ok}, 8'h00);
    wrsr_frame(8'h8C, 1'b1, ok); chk("R6 status write ignored while busy", {7'd0, ok}, 8'h00);
    wrdi_frame();
    chk("R6 clear ignored while busy", status_byte, 8'h03);
    busy = 1'b0;
    done_pulse();
  endtask

  task automatic t_hwprot();
    logic ok;
    // enable bit 0: WP low is ignored
    wren_frame();
    @(negedge clk); wp_n = 1'b0;
    wrsr_frame(8'h80, 1'b0, ok);
    chk("R8 wp ignored when enable 0", {7'd0, ok}, 8'h01);
    chk("R8 enable bit set", status_byte, 8'h82);
    // enable 1, WP low mid-frame then high again
    @(negedge clk); wp_n = 1'b1; cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h8C;
    @(negedge clk); wrsr_req = 1'b0; wp_n = 1'b0;
    @(negedge clk); wp_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R8 mid-frame wp low refuses", {sts_wr_ok, status_byte[6:0]}, 8'h02);
    // WP falls on the frame-end edge itself
    wrsr_frame(8'h8C, 1'b0, ok);
    chk("R8 wp low at frame end refuses", {7'd0, ok}, 8'h00);
    chk("R8 bits unchanged", status_byte, 8'h82);
    // array path unaffected by WP
    arr_try(13'h1FFF, ok); chk("R10 wp does not gate array", {7'd0, ok}, 8'h01);
    // commit, then WP drops after the commit
    @(negedge clk); wp_n = 1'b1;
    wrsr_frame(8'h84, 1'b1, ok);
    chk("R8 commit with wp high", {7'd0, ok}, 8'h01);
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    chk("R8 wp after commit no effect", status_byte, 8'h86);
    wp_n = 1'b1;
    done_pulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wren();
    t_wrdi();
    t_wrsr();
    t_ranges();
    t_busy();
    t_hwprot();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule